// File: doc/BRIEF.md
# Processor Reset Sequencer

This block stands between the board-level reset sources and a processor core. It drives a reset output toward the rest of the system and keeps that output high for a minimum time. The time is long after power comes up and short when a warm restart is requested while the clock is already running. It also accepts an external reset level that may change at any moment relative to the clock. That level goes through a two-flop synchronizer. The synchronizer output is set at once when the level rises, and it clears only on clock edges.

While reset is held, the core receives an init strobe that tells it to clear all of its state. When the hold ends, the controller spends exactly one cycle in a release step. In that cycle it samples the active-low flush pin to decide whether the core enters three-state test mode. On the edge that leaves the release step, it hands the core the fixed restart fetch address together with a one-cycle valid pulse.

The controller has four named states. POWER_ON_HOLD is entered on power-on reset. RUN is normal operation. WARM_HOLD is entered from RUN or RELEASE on a warm request or a synchronized external reset. RELEASE is the single cycle after either hold. The transitions are:
- POWER_ON_HOLD→RELEASE and WARM_HOLD→RELEASE, when the hold timer expires and no request is present.
- RELEASE→RUN, when no request is present.
- RELEASE→WARM_HOLD and RUN→WARM_HOLD, on a request.
- A request during either hold keeps the current state and restarts its timer.

Top module: `cpu_reset_sequencer`

## Requirements
- R1: While `pwr_on_n` is low, the block immediately sets `sys_reset`=1 and `core_init`=1, and sets `test_mode`=0, `fetch_valid`=0 and `fetch_addr`=0, without waiting for a clock edge.
- R2: After `pwr_on_n` rises, `sys_reset` stays high for exactly `CLK_MHZ*POR_TIME_US` rising edges. It goes low on the edge with that number.
- R3: A `warm_req` sampled high on a rising edge during RUN raises `sys_reset` on that edge. `sys_reset` then stays high for exactly `WARM_CYCLES` cycles, with a minimum of 15.
- R4: A request sampled during a hold restarts the hold timer. Release follows only after the full hold length has counted from the last request edge.
- R5: `ext_rst_in` is level-sensitive and may change asynchronously. `sys_reset` rises no later than the first rising edge after `ext_rst_in` rises. After `ext_rst_in` falls, `sys_reset` stays high for exactly `WARM_CYCLES+2` rising edges.
- R6: `test_mode` is loaded with the inverse of `flush_n` as sampled on the edge that ends RELEASE. It is 0 whenever `sys_reset` is high. Changes of `flush_n` during RUN have no effect on it.
- R7: On the first RUN cycle after a release, `fetch_valid` is high for exactly one cycle and `fetch_addr`=32'hFFFF_FFF0. `fetch_addr` keeps that value until the next hold, and it is 0 during holds.
- R8: `core_init` is high in every hold cycle and in the RELEASE cycle, and it is low in RUN.
- R9: RELEASE lasts exactly one cycle, with `sys_reset` low and `core_init` high. A request sampled in RELEASE returns the controller to WARM_HOLD for a full warm hold, and no fetch pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| pwr_on_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_in | input | 1 | External reset level, may be asynchronous |
| warm_req | input | 1 | Synchronous warm-restart request |
| flush_n | input | 1 | Active-low flush pin, sampled at release |
| sys_reset | output | 1 | Reset output toward the system |
| core_init | output | 1 | Init strobe to the core |
| test_mode | output | 1 | Three-state test-mode flag |
| fetch_valid | output | 1 | One-cycle pulse when the restart address is presented |
| fetch_addr | output | 32 | Restart fetch address |

## Verification
The assertions check these properties on every cycle:
- `core_init` covers `sys_reset`.
- RELEASE never lasts more than one cycle.
- The fetch pulse is single, coincides with the fall of `core_init`, and carries the fixed vector.
- The test-mode flag is clear during reset and steady in RUN.
- No reset hold is ever shorter than the warm minimum.

Only the bench scenarios can show the following:
- The exact hold lengths, including the two extra synchronizer cycles on external release.
- That a request arriving mid-hold or inside RELEASE restarts the full count.
- That both flush levels at release produce the matching test-mode value.

// File: rtl/cpu_rst_seq_pkg.sv
`timescale 1ns/1ps
package cpu_rst_seq_pkg;

    typedef enum logic [1:0] {
        ST_POWER_ON_HOLD = 2'd0,
        ST_RUN           = 2'd1,
        ST_WARM_HOLD     = 2'd2,
        ST_RELEASE       = 2'd3
    } seq_state_e;

    localparam logic [31:0] RESTART_VECTOR = 32'hFFFF_FFF0;

    function automatic logic is_hold(input seq_state_e s);
        return (s == ST_POWER_ON_HOLD) || (s == ST_WARM_HOLD);
    endfunction

endpackage

// File: rtl/cpu_rst_sync.sv
`timescale 1ns/1ps
// Reset-style synchronizer: asserts asynchronously, releases on clock edges.
module cpu_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pwr_on_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or posedge async_in or negedge pwr_on_n) begin
        if (!pwr_on_n) begin
            chain <= '0;
        end else if (async_in) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], 1'b0};
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/cpu_rst_hold_timer.sv
`timescale 1ns/1ps
// Shared hold counter; terminal count picked by the active hold kind.
module cpu_rst_hold_timer #(
    parameter int POR_CYCLES  = 250000,
    parameter int WARM_CYCLES = 15
) (
    input  logic clk,
    input  logic pwr_on_n,
    input  logic clear,
    input  logic por_mode,
    output logic done
);
    localparam int MAX_CYCLES = (POR_CYCLES > WARM_CYCLES) ? POR_CYCLES : WARM_CYCLES;
    localparam int CNT_W      = $clog2(MAX_CYCLES + 1);
    localparam logic [CNT_W-1:0] POR_LAST  = CNT_W'(POR_CYCLES - 1);
    localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(WARM_CYCLES - 1);

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] last;

    assign last = por_mode ? POR_LAST : WARM_LAST;
    assign done = (count == last);

    always_ff @(posedge clk or negedge pwr_on_n) begin
        if (!pwr_on_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (!done) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/cpu_rst_seq_fsm.sv
`timescale 1ns/1ps
module cpu_rst_seq_fsm
    import cpu_rst_seq_pkg::*;
(
    input  logic        clk,
    input  logic        pwr_on_n,
    input  logic        restart_req,
    input  logic        hold_done,
    input  logic        flush_n,
    output logic        timer_clear,
    output logic        por_mode,
    output logic        sys_reset,
    output logic        core_init,
    output logic        test_mode,
    output logic        fetch_valid,
    output logic [31:0] fetch_addr
);
    seq_state_e state, state_nxt;
    logic       go_run;

    // State register
    always_ff @(posedge clk or negedge pwr_on_n) begin
        if (!pwr_on_n) state <= ST_POWER_ON_HOLD;
        else           state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_POWER_ON_HOLD: if (!restart_req && hold_done) state_nxt = ST_RELEASE;
            ST_WARM_HOLD:     if (!restart_req && hold_done) state_nxt = ST_RELEASE;
            ST_RELEASE:       state_nxt = restart_req ? ST_WARM_HOLD : ST_RUN;
            ST_RUN:           if (restart_req) state_nxt = ST_WARM_HOLD;
        endcase
    end

    assign go_run = (state == ST_RELEASE) && (state_nxt == ST_RUN);

    // Decoded outputs
    always_comb begin
        sys_reset   = is_hold(state);
        core_init   = is_hold(state) || (state == ST_RELEASE);
        por_mode    = (state == ST_POWER_ON_HOLD);
        timer_clear = restart_req || !is_hold(state);
    end

    // Registered outputs loaded at release, cleared on hold entry
    always_ff @(posedge clk or negedge pwr_on_n) begin
        if (!pwr_on_n) begin
            test_mode   <= 1'b0;
            fetch_valid <= 1'b0;
            fetch_addr  <= '0;
        end else begin
            fetch_valid <= go_run;
            if (is_hold(state_nxt)) begin
                test_mode  <= 1'b0;
                fetch_addr <= '0;
            end else if (go_run) begin
                test_mode  <= ~flush_n;
                fetch_addr <= RESTART_VECTOR;
            end
        end
    end
endmodule

// File: rtl/cpu_reset_sequencer.sv
`timescale 1ns/1ps
module cpu_reset_sequencer #(
    parameter int CLK_MHZ     = 250,
    parameter int POR_TIME_US = 1000,
    parameter int WARM_CYCLES = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        pwr_on_n,
    input  logic        ext_rst_in,
    input  logic        warm_req,
    input  logic        flush_n,
    output logic        sys_reset,
    output logic        core_init,
    output logic        test_mode,
    output logic        fetch_valid,
    output logic [31:0] fetch_addr
);
    localparam int POR_CYCLES = CLK_MHZ * POR_TIME_US;

    initial begin
        if (WARM_CYCLES < 15)          $error("warm hold below minimum");
        if (SYNC_STAGES < 2)           $error("synchronizer too short");
        if (POR_CYCLES < WARM_CYCLES)  $error("power-on hold shorter than warm hold");
    end

    logic ext_rst_sync;
    logic restart_req;
    logic hold_done;
    logic timer_clear;
    logic por_mode;

    cpu_rst_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .pwr_on_n (pwr_on_n),
        .async_in (ext_rst_in),
        .sync_out (ext_rst_sync)
    );

    assign restart_req = warm_req | ext_rst_sync;

    cpu_rst_hold_timer #(
        .POR_CYCLES  (POR_CYCLES),
        .WARM_CYCLES (WARM_CYCLES)
    ) timer_i (
        .clk      (clk),
        .pwr_on_n (pwr_on_n),
        .clear    (timer_clear),
        .por_mode (por_mode),
        .done     (hold_done)
    );

    cpu_rst_seq_fsm fsm_i (
        .clk         (clk),
        .pwr_on_n    (pwr_on_n),
        .restart_req (restart_req),
        .hold_done   (hold_done),
        .flush_n     (flush_n),
        .timer_clear (timer_clear),
        .por_mode    (por_mode),
        .sys_reset   (sys_reset),
        .core_init   (core_init),
        .test_mode   (test_mode),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr)
    );
endmodule

// File: rtl/cpu_reset_sequencer_chk.sv
`timescale 1ns/1ps
module cpu_reset_sequencer_chk #(
    parameter int WARM_CYCLES = 15
) (
    input logic        clk,
    input logic        pwr_on_n,
    input logic        sys_reset,
    input logic        core_init,
    input logic        test_mode,
    input logic        fetch_valid,
    input logic [31:0] fetch_addr
);
    logic [31:0] high_run;

    always_ff @(posedge clk or negedge pwr_on_n) begin
        if (!pwr_on_n)      high_run <= '0;
        else if (sys_reset) high_run <= (high_run == 32'hFFFF_FFFF) ? high_run : high_run + 1'b1;
        else                high_run <= '0;
    end

    p_init_covers_reset_r8: assert property (@(posedge clk) disable iff (!pwr_on_n)
        sys_reset |-> core_init);

    p_release_single_r9: assert property (@(posedge clk) disable iff (!pwr_on_n)
        $fell(sys_reset) |=> (sys_reset || !core_init));

    p_fetch_vector_r7: assert property (@(posedge clk) disable iff (!pwr_on_n)
        fetch_valid |-> (fetch_addr == 32'hFFFF_FFF0 && !sys_reset));

    p_fetch_pulse_r7: assert property (@(posedge clk) disable iff (!pwr_on_n)
        fetch_valid |=> !fetch_valid);

    p_fetch_on_release_r7: assert property (@(posedge clk) disable iff (!pwr_on_n)
        fetch_valid == $fell(core_init));

    p_testmode_clear_r6: assert property (@(posedge clk) disable iff (!pwr_on_n)
        sys_reset |-> (!test_mode && fetch_addr == 32'h0));

    p_testmode_stable_r6: assert property (@(posedge clk) disable iff (!pwr_on_n)
        (!core_init && !fetch_valid) |-> $stable(test_mode));

    p_warm_min_r3: assert property (@(posedge clk) disable iff (!pwr_on_n)
        $fell(sys_reset) |-> (high_run >= 32'(WARM_CYCLES)));
endmodule

bind cpu_reset_sequencer cpu_reset_sequencer_chk #(.WARM_CYCLES(WARM_CYCLES)) chk_i (
    .clk         (clk),
    .pwr_on_n    (pwr_on_n),
    .sys_reset   (sys_reset),
    .core_init   (core_init),
    .test_mode   (test_mode),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr)
);

// File: tb/cpu_reset_sequencer_tb_top.sv
`timescale 1ns/1ps
module cpu_reset_sequencer_tb_top;
    localparam int B_CLK_MHZ = 250;
    localparam int B_POR_US  = 1;
    localparam int B_WARM    = 15;
    localparam int B_POR     = B_CLK_MHZ * B_POR_US;
    localparam logic [31:0] VEC = 32'hFFFF_FFF0;

    typedef struct packed {
        logic       use_ext;
        logic       flush_n;
        logic [7:0] exp_hold;
        logic       exp_tm;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b0, 1'b1, 8'(B_WARM),     1'b0},
        '{1'b0, 1'b0, 8'(B_WARM),     1'b1},
        '{1'b1, 1'b0, 8'(B_WARM + 2), 1'b1},
        '{1'b1, 1'b1, 8'(B_WARM + 2), 1'b0}
    };

    logic        clk = 1'b0;
    logic        pwr_on_n = 1'b0;
    logic        ext_rst_in = 1'b0;
    logic        warm_req = 1'b0;
    logic        flush_n = 1'b1;
    logic        sys_reset, core_init, test_mode, fetch_valid;
    logic [31:0] fetch_addr;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cpu_reset_sequencer #(
        .CLK_MHZ     (B_CLK_MHZ),
        .POR_TIME_US (B_POR_US),
        .WARM_CYCLES (B_WARM),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk         (clk),
        .pwr_on_n    (pwr_on_n),
        .ext_rst_in  (ext_rst_in),
        .warm_req    (warm_req),
        .flush_n     (flush_n),
        .sys_reset   (sys_reset),
        .core_init   (core_init),
        .test_mode   (test_mode),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Count negedge samples with sys_reset high, starting at the current one.
    task automatic measure_hold(output int n);
        n = 0;
        while (sys_reset === 1'b1 && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Called at the negedge where sys_reset was first seen low (RELEASE).
    task automatic post_release(input logic exp_tm);
        chk(core_init === 1'b1, "R8 core_init high in release", 32'(core_init), 32'd1);
        chk(fetch_valid === 1'b0, "R9 no fetch pulse in release", 32'(fetch_valid), 32'd0);
        @(negedge clk);
        chk(fetch_valid === 1'b1, "R7 fetch pulse on first run cycle", 32'(fetch_valid), 32'd1);
        chk(fetch_addr === VEC, "R7 restart vector", fetch_addr, VEC);
        chk(test_mode === exp_tm, "R6 test mode captured", 32'(test_mode), 32'(exp_tm));
        chk(core_init === 1'b0, "R8 core_init low in run", 32'(core_init), 32'd0);
        @(negedge clk);
        chk(fetch_valid === 1'b0, "R7 fetch pulse single", 32'(fetch_valid), 32'd0);
        chk(fetch_addr === VEC, "R7 vector held in run", fetch_addr, VEC);
    endtask

    task automatic warm_pulse();
        warm_req = 1'b1;
        @(negedge clk);
        warm_req = 1'b0;
    endtask

    initial begin
        int n;
        // R1: power-on state before any clock edge
        #1;
        chk(sys_reset === 1'b1, "R1 sys_reset at power-on", 32'(sys_reset), 32'd1);
        chk(core_init === 1'b1, "R1 core_init at power-on", 32'(core_init), 32'd1);
        chk(test_mode === 1'b0, "R1 test_mode at power-on", 32'(test_mode), 32'd0);
        chk(fetch_valid === 1'b0, "R1 fetch_valid at power-on", 32'(fetch_valid), 32'd0);
        chk(fetch_addr === 32'h0, "R1 fetch_addr at power-on", fetch_addr, 32'h0);
        repeat (3) @(negedge clk);
        pwr_on_n = 1'b1;
        measure_hold(n);
        chk(n == B_POR, "R2 power-on hold length", 32'(n), 32'(B_POR));
        post_release(1'b0);

        // Table-driven warm and external resets, both flush levels
        for (int i = 0; i < 4; i++) begin
            flush_n = VECS[i].flush_n;
            @(negedge clk);
            if (VECS[i].use_ext) begin
                ext_rst_in = 1'b1;
                #0.5;
                chk(ext_rst_in === 1'b1 && sys_reset === 1'b0, "R5 before edge", 32'(sys_reset), 32'd0);
                @(negedge clk);
                chk(sys_reset === 1'b1, "R5 asserted after one edge", 32'(sys_reset), 32'd1);
                repeat (2) @(negedge clk);
                ext_rst_in = 1'b0;
                measure_hold(n);
                chk(n == int'(VECS[i].exp_hold), "R5 external release hold", 32'(n), 32'(VECS[i].exp_hold));
            end else begin
                warm_pulse();
                chk(test_mode === 1'b0, "R6 test mode clear in hold", 32'(test_mode), 32'd0);
                measure_hold(n);
                chk(n == int'(VECS[i].exp_hold), "R3 warm hold length", 32'(n), 32'(VECS[i].exp_hold));
            end
            post_release(VECS[i].exp_tm);
            flush_n = ~flush_n;
            repeat (2) @(negedge clk);
            chk(test_mode === VECS[i].exp_tm, "R6 flush ignored in run", 32'(test_mode), 32'(VECS[i].exp_tm));
        end

        // R4: second request mid-hold restarts the count
        flush_n = 1'b1;
        @(negedge clk);
        warm_pulse();
        repeat (5) @(negedge clk);
        warm_pulse();
        measure_hold(n);
        chk(n == B_WARM, "R4 restart mid-hold", 32'(n), 32'(B_WARM));
        post_release(1'b0);

        // R9: request inside the release cycle
        warm_pulse();
        measure_hold(n);
        chk(n == B_WARM, "R3 warm hold before release restart", 32'(n), 32'(B_WARM));
        warm_req = 1'b1;
        @(negedge clk);
        warm_req = 1'b0;
        chk(sys_reset === 1'b1, "R9 release returns to hold", 32'(sys_reset), 32'd1);
        chk(fetch_valid === 1'b0, "R9 no fetch after release restart", 32'(fetch_valid), 32'd0);
        measure_hold(n);
        chk(n == B_WARM, "R9 full hold after release restart", 32'(n), 32'(B_WARM));
        post_release(1'b0);

        // R1: asynchronous power-on clear in the middle of run
        flush_n = 1'b0;
        warm_pulse();
        measure_hold(n);
        post_release(1'b1);
        #1 pwr_on_n = 1'b0;
        #0.5;
        chk(sys_reset === 1'b1, "R1 async sys_reset", 32'(sys_reset), 32'd1);
        chk(test_mode === 1'b0, "R1 async test_mode clear", 32'(test_mode), 32'd0);
        chk(fetch_addr === 32'h0, "R1 async fetch_addr clear", fetch_addr, 32'h0);
        @(negedge clk);
        flush_n = 1'b1;
        pwr_on_n = 1'b1;
        measure_hold(n);
        chk(n == B_POR, "R2 second power-on hold", 32'(n), 32'(B_POR));
        post_release(1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R2 actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule